// File: doc/BRIEF.md
# Fuse Logical Map Decoder

This block expands a packed physical fuse image into a byte-addressed logical map. On a start pulse it first writes the erased value into every byte of the logical map. It then walks the physical image packet by packet. A packet is a two-byte header followed by zero to four two-byte data words. The header carries an 8-bit block index, split across its two bytes, and a 4-bit mask in which a one marks a word that is not stored. Each stored word lands in the logical map at a position derived from the block index and the word's slot number.

Both memories sit outside the block. Each is single-ported and moves one byte per cycle. The physical memory returns read data one cycle after the read strobe. The caller supplies the physical image size, the size of a reserved region kept at both ends of the physical image, and the logical map size. The block signals completion with a one-cycle done pulse. An error flag reports a packet that would run past either bound.

Top module: `fuse_logmap_dec`

## Requirements
- R1: After start, logical bytes 0 to log_size−1 are written with 0xFF in ascending address order, before any decoded byte is written.
- R2: Parsing begins at physical offset rsv_size and continues while offset + rsv_size < phy_size. Reaching that limit ends the run with err = 0.
- R3: A header whose first byte or second byte equals 0xFF ends the run with err = 0. No further logical write follows it.
- R4: The block index is {hdr1[3:0], hdr2[7:4]}. Word slot i goes to logical bytes index×8 + 2i and index×8 + 2i + 1, taking the lower physical address first.
- R5: Bit i of hdr2[3:0] set to 1 means slot i is absent and consumes no physical bytes. Present slots take the following byte pairs in ascending slot order.
- R6: A word whose second byte would sit at a physical offset greater than phy_size − rsv_size − 1 ends the run with err = 1. That word is not written.
- R7: A word with logical offset + 1 > log_size ends the run with err = 1. That word is not written.
- R8: done is high for exactly one cycle per run, whether the run ends normally or with an error. err is valid from done until the next accepted start, which clears it.
- R9: A start pulse that arrives while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| phy_size | input | PHY_AW | Physical image size in bytes |
| rsv_size | input | PHY_AW | Reserved region size at each end of the image |
| log_size | input | LOG_AW | Logical map size in bytes |
| phy_re | output | 1 | Physical memory read strobe |
| phy_addr | output | PHY_AW | Physical memory byte address |
| phy_rdata | input | 8 | Physical read data, one cycle after phy_re |
| log_we | output | 1 | Logical memory write strobe |
| log_addr | output | LOG_AW | Logical memory byte address |
| log_wdata | output | 8 | Logical write data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Bound violation flag for the last run |

## Verification
Both the physical-window check and the logical-size check are evaluated on the same word in the same cycle. A vector places a packet whose first present slot, at offset 16, breaks both bounds at once: the window ends at 15 and the target slot lies past a 40-byte map. That vector is judged by a single err = 1 and a single done pulse. The logical map must match the reference, holding only the earlier packet's words, so the rejected word is confirmed unwritten. Two more vectors trip each bound on its own. A fourth places the last word exactly on the window edge and shows that it is still accepted.

// File: rtl/fuse_map_pkg.sv
package fuse_map_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned NIB_W  = 4;
   localparam int unsigned BLK_W  = 2 * NIB_W;

   typedef enum logic [3:0] {
      S_IDLE,
      S_FILL,
      S_LOOP,
      S_HDR1,
      S_HDR2,
      S_WSEL,
      S_WB0,
      S_WB1,
      S_DONE
   } dec_state_e;

endpackage

// File: rtl/fuse_hdr_split.sv
module fuse_hdr_split
   import fuse_map_pkg::*;
#(
   parameter logic [BYTE_W-1:0] END_CODE = 8'hFF
) (
   input  logic [BYTE_W-1:0] hdr1,
   input  logic [BYTE_W-1:0] hdr2,
   output logic              is_end,
   output logic [BLK_W-1:0]  blk,
   output logic [NIB_W-1:0]  absent
);

   // Either byte still erased means the written area ends here.
   assign is_end = (hdr1 == END_CODE) || (hdr2 == END_CODE);

   // Low nibble of the first byte is the high half of the index.
   assign blk    = {hdr1[NIB_W-1:0], hdr2[BYTE_W-1:NIB_W]};

   // A one marks a slot that is not stored in the image.
   assign absent = hdr2[NIB_W-1:0];

endmodule

// File: rtl/fuse_word_pick.sv
module fuse_word_pick #(
   parameter int unsigned NW   = 4,
   parameter int unsigned IW   = $clog2(NW)
) (
   input  logic [NW-1:0] absent,
   input  logic [IW:0]   from,
   output logic          found,
   output logic [IW-1:0] idx
);

   logic [NW-1:0] cand;

   // A slot qualifies when it is stored and not yet visited.
   for (genvar gi = 0; gi < NW; gi++) begin : g_cand
      assign cand[gi] = !absent[gi] && (from <= (IW+1)'(gi));
   end

   // Lowest qualifying slot wins.
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = NW - 1; i >= 0; i--) begin
         if (cand[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end

endmodule

// File: rtl/fuse_bound_chk.sv
module fuse_bound_chk #(
   parameter int unsigned PHY_AW = 9,
   parameter int unsigned LOG_AW = 8,
   parameter int unsigned LIDX_W = 11
) (
   input  logic [PHY_AW:0]   off,
   input  logic [PHY_AW-1:0] rsv,
   input  logic [PHY_AW-1:0] psize,
   input  logic [LIDX_W-1:0] lidx,
   input  logic [LOG_AW-1:0] lsize,
   output logic              more,
   output logic              phy_bad,
   output logic              log_bad
);

   localparam int unsigned MA = (PHY_AW + 1 > LIDX_W) ? PHY_AW + 1 : LIDX_W;
   localparam int unsigned MB = (MA > LOG_AW) ? MA : LOG_AW;
   localparam int unsigned CW = MB + 2;

   logic [CW-1:0] off_w, rsv_w, psz_w, lidx_w, lsz_w;

   assign off_w  = CW'(off);
   assign rsv_w  = CW'(rsv);
   assign psz_w  = CW'(psize);
   assign lidx_w = CW'(lidx);
   assign lsz_w  = CW'(lsize);

   // off < psize - rsv, moved to the other side so no term can go negative.
   assign more    = (off_w + rsv_w) < psz_w;

   // Second byte at off+1 beyond psize - rsv - 1, rearranged the same way.
   assign phy_bad = (off_w + rsv_w + CW'(2)) > psz_w;

   // Second logical byte index compared against the map size.
   assign log_bad = (lidx_w + CW'(1)) > lsz_w;

endmodule

// File: rtl/fuse_logmap_dec.sv
module fuse_logmap_dec
   import fuse_map_pkg::*;
#(
   parameter int unsigned      PHY_AW = 9,
   parameter int unsigned      LOG_AW = 8,
   parameter int unsigned      WPB    = 4,
   parameter logic [BYTE_W-1:0] ERASED = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PHY_AW-1:0] phy_size,
   input  logic [PHY_AW-1:0] rsv_size,
   input  logic [LOG_AW-1:0] log_size,
   output logic              phy_re,
   output logic [PHY_AW-1:0] phy_addr,
   input  logic [BYTE_W-1:0] phy_rdata,
   output logic              log_we,
   output logic [LOG_AW-1:0] log_addr,
   output logic [BYTE_W-1:0] log_wdata,
   output logic              done,
   output logic              err
);

   localparam int unsigned WI_W   = $clog2(WPB);
   localparam int unsigned SLOT_SH = WI_W + 1;
   localparam int unsigned LIDX_W = BLK_W + SLOT_SH;
   localparam int unsigned OFF_W  = PHY_AW + 1;

   // Elaboration checks on the parameter set.
   if (WPB != NIB_W) begin : g_bad_wpb
      $error("WPB must equal the header mask width");
   end
   if (PHY_AW < 3 || PHY_AW > 16) begin : g_bad_phy
      $error("PHY_AW out of supported range");
   end
   if (LOG_AW < 3 || LOG_AW > 16) begin : g_bad_log
      $error("LOG_AW out of supported range");
   end

   dec_state_e          st_q;
   logic [LOG_AW-1:0]   fill_q;
   logic [OFF_W-1:0]    off_q;
   logic [BYTE_W-1:0]   hdr1_q;
   logic [BLK_W-1:0]    blk_q;
   logic [WPB-1:0]      absent_q;
   logic [WI_W:0]       widx_q;
   logic [WI_W-1:0]     cur_w_q;
   logic [LIDX_W-1:0]   lidx_q;
   logic                err_q;

   logic                hdr_end;
   logic [BLK_W-1:0]    hdr_blk;
   logic [NIB_W-1:0]    hdr_absent;
   logic                pick_found;
   logic [WI_W-1:0]     pick_idx;
   logic [LIDX_W-1:0]   lidx_c;
   logic                win_more;
   logic                phy_bad;
   logic                log_bad;
   logic                word_bad;

   fuse_hdr_split #(
      .END_CODE (ERASED)
   ) u_hdr (
      .hdr1   (hdr1_q),
      .hdr2   (phy_rdata),
      .is_end (hdr_end),
      .blk    (hdr_blk),
      .absent (hdr_absent)
   );

   fuse_word_pick #(
      .NW (WPB),
      .IW (WI_W)
   ) u_pick (
      .absent (absent_q),
      .from   (widx_q),
      .found  (pick_found),
      .idx    (pick_idx)
   );

   // Slot position: block index times slot bytes plus twice the slot number.
   assign lidx_c = (LIDX_W'(blk_q) << SLOT_SH) + LIDX_W'({pick_idx, 1'b0});

   fuse_bound_chk #(
      .PHY_AW (PHY_AW),
      .LOG_AW (LOG_AW),
      .LIDX_W (LIDX_W)
   ) u_bound (
      .off     (off_q),
      .rsv     (rsv_size),
      .psize   (phy_size),
      .lidx    (lidx_c),
      .lsize   (log_size),
      .more    (win_more),
      .phy_bad (phy_bad),
      .log_bad (log_bad)
   );

   assign word_bad = phy_bad || log_bad;

   // Sequencer: fill pass, then header and word fetches one byte per cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= S_IDLE;
         fill_q   <= '0;
         off_q    <= '0;
         hdr1_q   <= '0;
         blk_q    <= '0;
         absent_q <= '0;
         widx_q   <= '0;
         cur_w_q  <= '0;
         lidx_q   <= '0;
         err_q    <= 1'b0;
      end else begin
         unique case (st_q)
            S_IDLE: begin
               if (start) begin
                  err_q  <= 1'b0;
                  fill_q <= '0;
                  off_q  <= OFF_W'(rsv_size);
                  st_q   <= (log_size == '0) ? S_LOOP : S_FILL;
               end
            end
            S_FILL: begin
               fill_q <= fill_q + LOG_AW'(1);
               if (fill_q == (log_size - LOG_AW'(1))) begin
                  st_q <= S_LOOP;
               end
            end
            S_LOOP: begin
               st_q <= win_more ? S_HDR1 : S_DONE;
            end
            S_HDR1: begin
               hdr1_q <= phy_rdata;
               st_q   <= S_HDR2;
            end
            S_HDR2: begin
               if (hdr_end) begin
                  st_q <= S_DONE;
               end else begin
                  blk_q    <= hdr_blk;
                  absent_q <= hdr_absent;
                  widx_q   <= '0;
                  off_q    <= off_q + OFF_W'(2);
                  st_q     <= S_WSEL;
               end
            end
            S_WSEL: begin
               if (!pick_found) begin
                  st_q <= S_LOOP;
               end else if (word_bad) begin
                  err_q <= 1'b1;
                  st_q  <= S_DONE;
               end else begin
                  cur_w_q <= pick_idx;
                  lidx_q  <= lidx_c;
                  st_q    <= S_WB0;
               end
            end
            S_WB0: begin
               st_q <= S_WB1;
            end
            S_WB1: begin
               off_q  <= off_q + OFF_W'(2);
               widx_q <= (WI_W+1)'(cur_w_q) + (WI_W+1)'(1);
               st_q   <= S_WSEL;
            end
            S_DONE: begin
               st_q <= S_IDLE;
            end
            default: begin
               st_q <= S_IDLE;
            end
         endcase
      end
   end

   // Memory strobes.
   always_comb begin
      phy_re    = 1'b0;
      phy_addr  = '0;
      log_we    = 1'b0;
      log_addr  = '0;
      log_wdata = ERASED;
      unique case (st_q)
         S_FILL: begin
            log_we   = 1'b1;
            log_addr = fill_q;
         end
         S_LOOP: begin
            phy_re   = win_more;
            phy_addr = PHY_AW'(off_q);
         end
         S_HDR1: begin
            phy_re   = 1'b1;
            phy_addr = PHY_AW'(off_q + OFF_W'(1));
         end
         S_WSEL: begin
            phy_re   = pick_found && !word_bad;
            phy_addr = PHY_AW'(off_q);
         end
         S_WB0: begin
            log_we    = 1'b1;
            log_addr  = LOG_AW'(lidx_q);
            log_wdata = phy_rdata;
            phy_re    = 1'b1;
            phy_addr  = PHY_AW'(off_q + OFF_W'(1));
         end
         S_WB1: begin
            log_we    = 1'b1;
            log_addr  = LOG_AW'(lidx_q + LIDX_W'(1));
            log_wdata = phy_rdata;
         end
         default: begin
         end
      endcase
   end

   assign done = (st_q == S_DONE);
   assign err  = err_q;

   // Completion is a single-cycle pulse.
   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // The error flag only turns on together with completion.
   assert_err_rises_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> done);

   // Word fetches stay inside the window that ends rsv_size before the image end.
   assert_word_read_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_re && (st_q == S_WSEL || st_q == S_WB0)) |->
      ((32'(phy_addr) + 32'(rsv_size) + 32'd1) <= 32'(phy_size)));

   // Decoded writes never pass the logical bound.
   assert_log_write_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (log_we && st_q != S_FILL) |-> (log_addr <= log_size));

   // A fetched word always belongs to a slot the header marked as stored.
   assert_picked_word_present_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_WB0) |-> !absent_q[cur_w_q]);

endmodule

// File: tb/fuse_logmap_dec_tb.sv
module fuse_logmap_dec_tb_top;

   localparam int PA = 9;
   localparam int LA = 8;
   localparam int PDEPTH = 1 << PA;
   localparam int LDEPTH = 1 << LA;
   localparam logic [7:0] POISON = 8'h5A;

   typedef struct packed {
      logic [8:0]   p;
      logic [8:0]   r;
      logic [7:0]   l;
      logic         e;
      logic [3:0]   req;
      logic [127:0] img;
   } vec_t;

   // Image bytes start at offset r, first byte in the top bits; rest erased.
   // req names the requirement each vector targets: R4, R5, R4, R7, R6, R2, R3, R3, R6.
   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{9'd64, 9'd4, 8'd64, 1'b0, 4'd4, 128'h0010_1122_3344_5566_7788_FFFF_FFFF_FFFF},
      '{9'd64, 9'd0, 8'd64, 1'b0, 4'd5, 128'h002A_A1A2_B1B2_003E_C1C2_FFFF_FFFF_FFFF},
      '{9'd100,9'd2, 8'd200,1'b0, 4'd4, 128'h0150_D1D2_D3D4_D5D6_D7D8_FFFF_FFFF_FFFF},
      '{9'd64, 9'd0, 8'd40, 1'b1, 4'd7, 128'h004C_3132_3334_005E_4142_FFFF_FFFF_FFFF},
      '{9'd20, 9'd4, 8'd64, 1'b1, 4'd6, 128'h0060_E0E1_E2E3_E4E5_E6E7_007E_7172_FFFF},
      '{9'd16, 9'd2, 8'd64, 1'b0, 4'd2, 128'h006E_6162_007E_7172_000E_0102_0010_9999},
      '{9'd64, 9'd0, 8'd64, 1'b0, 4'd3, 128'h00FF_1122_3344_FFFF_FFFF_FFFF_FFFF_FFFF},
      '{9'd64, 9'd0, 8'd64, 1'b0, 4'd3, 128'hFF10_2233_4455_FFFF_FFFF_FFFF_FFFF_FFFF},
      '{9'd20, 9'd4, 8'd40, 1'b1, 4'd6, 128'h0010_E0E1_E2E3_E4E5_E6E7_007E_7172_FFFF}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [PA-1:0] psz = '0;
   logic [PA-1:0] rsz = '0;
   logic [LA-1:0] lsz = '0;
   logic          phy_re;
   logic [PA-1:0] phy_addr;
   logic [7:0]    phy_q = '0;
   logic          log_we;
   logic [LA-1:0] log_addr;
   logic [7:0]    log_wdata;
   logic          done;
   logic          err;

   logic [7:0] phy_mem [PDEPTH];
   logic [7:0] log_mem [LDEPTH];
   logic [7:0] exp_map [LDEPTH];

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int wr_n = 0;
   int cur_l = 0;
   int order_bad = 0;
   int done_n = 0;

   always #5 clk = ~clk;

   fuse_logmap_dec #(
      .PHY_AW (PA),
      .LOG_AW (LA)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .phy_size  (psz),
      .rsv_size  (rsz),
      .log_size  (lsz),
      .phy_re    (phy_re),
      .phy_addr  (phy_addr),
      .phy_rdata (phy_q),
      .log_we    (log_we),
      .log_addr  (log_addr),
      .log_wdata (log_wdata),
      .done      (done),
      .err       (err)
   );

   // Memory models and write-order monitor for R1.
   always @(posedge clk) begin
      if (phy_re) phy_q <= phy_mem[phy_addr];
      if (log_we) begin
         log_mem[log_addr] <= log_wdata;
         if (wr_n < cur_l && (int'(log_addr) != wr_n || log_wdata != 8'hFF)) order_bad++;
         wr_n++;
      end
      if (done) done_n++;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         total++;
         bad++;
         $display("FAIL R8 watchdog act=%0d exp=%0d", cyc, 150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   // Independent walk of the image following R1..R7.
   task automatic ref_decode(input int p, input int r, input int l, output bit e);
      int off;
      int blk;
      int li;
      logic [7:0] h1, h2;
      bit stop;
      e = 1'b0;
      stop = 1'b0;
      for (int i = 0; i < LDEPTH; i++) exp_map[i] = (i < l) ? 8'hFF : POISON;
      off = r;
      while (!stop && off < p - r) begin
         h1 = phy_mem[off];
         h2 = phy_mem[off + 1];
         if (h1 == 8'hFF || h2 == 8'hFF) begin
            stop = 1'b1;
         end else begin
            blk = {h1[3:0], h2[7:4]};
            off += 2;
            for (int w = 0; w < 4; w++) begin
               if (!stop && !h2[w]) begin
                  li = blk * 8 + w * 2;
                  if (off + 1 > p - r - 1 || li + 1 > l) begin
                     e = 1'b1;
                     stop = 1'b1;
                  end else begin
                     exp_map[li] = phy_mem[off];
                     exp_map[li + 1] = phy_mem[off + 1];
                     off += 2;
                  end
               end
            end
         end
      end
   endtask

   task automatic load_img(input int r, input logic [127:0] img);
      for (int i = 0; i < PDEPTH; i++) phy_mem[i] = 8'hFF;
      for (int k = 0; k < 16; k++) phy_mem[r + k] = img[127 - 8 * k -: 8];
   endtask

   task automatic arm(input int p, input int r, input int l);
      @(negedge clk);
      psz = PA'(p);
      rsz = PA'(r);
      lsz = LA'(l);
      cur_l = l;
      wr_n = 0;
      order_bad = 0;
      done_n = 0;
      for (int i = 0; i < LDEPTH; i++) log_mem[i] = POISON;
   endtask

   task automatic wait_done();
      for (int k = 0; k < 6000; k++) begin
         if (done_n > 0) break;
         @(negedge clk);
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic map_check(input string req);
      int miss;
      int first;
      miss = 0;
      first = -1;
      for (int i = 0; i < LDEPTH; i++) begin
         if (log_mem[i] !== exp_map[i]) begin
            if (first < 0) first = i;
            miss++;
         end
      end
      if (first < 0) chk(1'b1, req, 0, 0);
      else chk(1'b0, req, int'(log_mem[first]), int'(exp_map[first]));
   endtask

   initial begin
      bit e_ref;
      for (int i = 0; i < LDEPTH; i++) log_mem[i] = POISON;
      for (int i = 0; i < PDEPTH; i++) phy_mem[i] = 8'hFF;

      // Reset state (R8: no done, no err while held in reset).
      repeat (3) @(negedge clk);
      chk(done == 1'b0, "R8 reset done", int'(done), 0);
      chk(err == 1'b0, "R8 reset err", int'(err), 0);
      chk(phy_re == 1'b0 && log_we == 1'b0, "R1 reset strobes", int'(phy_re | log_we), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Vector table walk.
      for (int v = 0; v < NV; v++) begin
         load_img(int'(VECS[v].r), VECS[v].img);
         arm(int'(VECS[v].p), int'(VECS[v].r), int'(VECS[v].l));
         ref_decode(int'(VECS[v].p), int'(VECS[v].r), int'(VECS[v].l), e_ref);
         start = 1'b1;
         @(negedge clk);
         start = 0;
         wait_done();
         chk(err == VECS[v].e, $sformatf("R%0d err vec%0d", VECS[v].req, v),
             int'(err), int'(VECS[v].e));
         map_check($sformatf("R%0d map vec%0d", VECS[v].req, v));
         chk(order_bad == 0, $sformatf("R1 fill order vec%0d", v), order_bad, 0);
         chk(done_n == 1, $sformatf("R8 done count vec%0d", v), done_n, 1);
      end

      // R8: err holds after an error run, then clears on the next start.
      load_img(0, VECS[3].img);
      arm(64, 0, 40);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      repeat (10) @(negedge clk);
      chk(err == 1'b1, "R8 err held", int'(err), 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(err == 1'b0, "R8 err cleared by start", int'(err), 0);
      chk(done == 1'b0, "R8 no done at start", int'(done), 0);
      done_n = 0;
      wait_done();
      chk(done_n == 1, "R8 second run done", done_n, 1);

      // R9: start pulses during a run are ignored.
      load_img(4, VECS[0].img);
      arm(64, 4, 64);
      ref_decode(64, 4, 64, e_ref);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      start = 1'b1;
      repeat (3) @(negedge clk);
      start = 1'b0;
      wait_done();
      repeat (100) @(negedge clk);
      chk(done_n == 1, "R9 busy start ignored", done_n, 1);
      map_check("R9 map after busy start");
      chk(order_bad == 0, "R9 R1 single fill pass", order_bad, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule